// File: doc/BRIEF.md
# Multi-Mode Raster Timing Generator

This block produces the horizontal and vertical raster timing of a display controller that supports three field rates: 50 Hz and 60 Hz colour modes and a 72 Hz monochrome mode. A horizontal cycle counter drives the horizontal blank, enable and sync flags. A line counter advances once per line and drives the vertical blank, enable and sync flags. The outputs are hsync, vsync, a combined blank, a combined display enable and a pixel-depth code. There is no data stream through the block: all pins are plain control and status pins, and register writes are single-cycle strobes with no back-pressure.

Two write-only registers select the mode. The mode register fixes the colour depth, and the rate register picks between 50 Hz and 60 Hz. The active mode selects one of three horizontal event tables at run time. The line length does not follow the table at once, however. It is copied into a latch only at a fixed mid-line cycle, and both the sync edges and the counter wrap use that latched length. Vertical line ranges and line totals are module parameters.

Timing convention: after reset is released the counter holds the value k during the cycle that follows k rising edges. An event placed at count E takes effect in the same cycle in which the counter reads E.

Top module: `raster_timer`

## Requirements
- R1: While reset is held and at release, both counters are 0, hsync and vsync are low, disp_en is low, depth is 0, field_mode is 0 (50 Hz), and the line-0 vertical state of the 50 Hz table is in force.
- R2: Register select 1 is the mode register and takes effect on the edge that captures the write. Select 0 is the rate register. A write to it takes effect one clock after the capturing edge, so field_mode is still unchanged in the cycle right after that edge.
- R3: Mode-register bits [9:8] set depth: 0 gives code 0 (4 bpp), 1 gives code 1 (2 bpp), and 2 or 3 give code 2 (1 bpp). A depth code of 2 forces field_mode 2 (72 Hz). Otherwise rate-register bit 9 gives field_mode 0 (50 Hz) when set and 1 (60 Hz) when clear.
- R4: The horizontal events for 50 Hz are: blank off at 28, enable on at 56, enable off at 376, blank on at 450, length 512. For 60 Hz they are 24, 52, 372, 450 and 508. For 72 Hz, enable is on at 4 and off at 164, the length is 224, and horizontal blank never changes.
- R5: The line length is loaded from the active table only in the cycle the counter reaches 54. The counter wraps to 0 after reaching the latched length minus 1.
- R6: hsync rises at the latched length minus 48 and falls at the latched length minus 8, so it is high for 40 cycles. Its rising edge also clears horizontal enable.
- R7: The vertical state of the next line is decided at count 502, or at the last count of the line if the line is shorter. The decision uses the table of the mode in force at that moment, and the new state takes effect at count 0. A line L is blanked when L < blank-end or L >= blank-start, and is enabled when en-start <= L < en-end. The line counter wraps to 0 at the table total.
- R8: Vertical sync for a line is asserted when vs-start <= L < vs-end, and it changes only at count 54 of that line.
- R9: disp_en is the AND of the horizontal and vertical enables. blank is the OR of the horizontal and vertical blanks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one horizontal cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = rate register, 1 = mode register |
| wr_data | input | 16 | Write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Horizontal or vertical blank |
| disp_en | output | 1 | Display enable |
| depth | output | 2 | Pixel depth code (0: 4 bpp, 1: 2 bpp, 2: 1 bpp) |
| field_mode | output | 2 | Active mode (0: 50 Hz, 1: 60 Hz, 2: 72 Hz) |

## Verification
If the latched length is wrong, the next hsync rising edge lands a few cycles early or late, within one line of the fault. A wrong horizontal counter shifts every horizontal edge on the same line. A wrong line counter or a wrong vertical decision shows up at the next line start as a blank or enable pattern that does not match the expected line. A vsync placed off count 54 is visible on the line where it should change. A rate write that is applied one cycle too early can be seen on field_mode in the cycle right after the write.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [1:0] {FM_50 = 2'd0, FM_60 = 2'd1, FM_72 = 2'd2} field_t;
  typedef enum logic [1:0] {DEP_4 = 2'd0, DEP_2 = 2'd1, DEP_1 = 2'd2} depth_t;

  typedef struct packed {
    logic [15:0] blk_clr;
    logic [15:0] en_set;
    logic [15:0] en_clr;
    logic [15:0] blk_set;
    logic [15:0] length;
    logic        has_blank;
  } htiming_t;

  typedef struct packed {
    logic [15:0] total;
    logic [15:0] blk_end;
    logic [15:0] en_start;
    logic [15:0] en_end;
    logic [15:0] blk_start;
    logic [15:0] vs_start;
    logic [15:0] vs_end;
  } vtiming_t;

  localparam htiming_t H50_DEF = '{blk_clr: 16'd28, en_set: 16'd56, en_clr: 16'd376,
                                   blk_set: 16'd450, length: 16'd512, has_blank: 1'b1};
  localparam htiming_t H60_DEF = '{blk_clr: 16'd24, en_set: 16'd52, en_clr: 16'd372,
                                   blk_set: 16'd450, length: 16'd508, has_blank: 1'b1};
  localparam htiming_t H72_DEF = '{blk_clr: 16'd0, en_set: 16'd4, en_clr: 16'd164,
                                   blk_set: 16'd0, length: 16'd224, has_blank: 1'b0};

  localparam vtiming_t V50_DEF = '{total: 16'd313, blk_end: 16'd34, en_start: 16'd63,
                                   en_end: 16'd263, blk_start: 16'd308,
                                   vs_start: 16'd310, vs_end: 16'd313};
  localparam vtiming_t V60_DEF = '{total: 16'd263, blk_end: 16'd16, en_start: 16'd34,
                                   en_end: 16'd234, blk_start: 16'd258,
                                   vs_start: 16'd260, vs_end: 16'd263};
  localparam vtiming_t V72_DEF = '{total: 16'd501, blk_end: 16'd0, en_start: 16'd34,
                                   en_end: 16'd434, blk_start: 16'd501,
                                   vs_start: 16'd498, vs_end: 16'd500};

  // Vertical state of one line: {blank, enable, sync}
  function automatic logic [2:0] vrow(vtiming_t t, logic [15:0] ln);
    logic b, e, s;
    b = (ln < t.blk_end) || (ln >= t.blk_start);
    e = (ln >= t.en_start) && (ln < t.en_end);
    s = (ln >= t.vs_start) && (ln < t.vs_end);
    return {b, e, s};
  endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH_LSB = 8,
  parameter int RATE_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output field_t            field_mode,
  output depth_t            depth
);

  localparam logic [DATA_W-1:0] RATE_RST = DATA_W'(1) << RATE_BIT;

  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] rate_q;
  logic [DATA_W-1:0] rate_pend_q;
  logic              rate_pend_vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q          <= '0;
      rate_q          <= RATE_RST;
      rate_pend_q     <= RATE_RST;
      rate_pend_vld_q <= 1'b0;
    end else begin
      rate_pend_vld_q <= wr_en && !wr_sel;
      if (wr_en && !wr_sel) rate_pend_q <= wr_data;
      if (rate_pend_vld_q) rate_q <= rate_pend_q;
      if (wr_en && wr_sel) mode_q <= wr_data;
    end
  end

  always_comb begin
    unique case (mode_q[DEPTH_LSB +: 2])
      2'd0:    depth = DEP_4;
      2'd1:    depth = DEP_2;
      default: depth = DEP_1;
    endcase
    if (depth == DEP_1)       field_mode = FM_72;
    else if (rate_q[RATE_BIT]) field_mode = FM_50;
    else                       field_mode = FM_60;
  end

endmodule

// File: rtl/raster_htimer.sv
module raster_htimer
  import raster_pkg::*;
#(
  parameter int       CNT_W      = 10,
  parameter htiming_t H50        = H50_DEF,
  parameter htiming_t H60        = H60_DEF,
  parameter htiming_t H72        = H72_DEF,
  parameter int       SYNC_LEAD  = 48,
  parameter int       SYNC_TRAIL = 8,
  parameter int       LATCH_AT   = 54,
  parameter int       VSYNC_AT   = 54,
  parameter int       DECIDE_AT  = 502
) (
  input  logic             clk,
  input  logic             rst_n,
  input  field_t           field_mode,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] line_len,
  output logic             hblank,
  output logic             hen,
  output logic             hsync,
  output logic             wrap_s,
  output logic             decide_s,
  output logic             vsync_s
);

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] LATCH_C = CNT_W'(LATCH_AT);
  localparam logic [CNT_W-1:0] VSYNC_C = CNT_W'(VSYNC_AT);
  localparam logic [CNT_W-1:0] DEC_C   = CNT_W'(DECIDE_AT);

  htiming_t         row;
  logic [CNT_W-1:0] nxt, last, sync_on, sync_off, dec_at;
  logic [15:0]      nxt16;

  always_comb begin
    unique case (field_mode)
      FM_60:   row = H60;
      FM_72:   row = H72;
      default: row = H50;
    endcase
  end

  assign last     = line_len - ONE;
  assign nxt      = (hcnt >= last) ? '0 : hcnt + ONE;
  assign nxt16    = 16'(nxt);
  assign sync_on  = line_len - CNT_W'(SYNC_LEAD);
  assign sync_off = line_len - CNT_W'(SYNC_TRAIL);
  assign dec_at   = (last < DEC_C) ? last : DEC_C;

  assign wrap_s   = (nxt == '0);
  assign decide_s = (nxt == dec_at);
  assign vsync_s  = (nxt == VSYNC_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt     <= '0;
      line_len <= CNT_W'(H50.length);
      hblank   <= 1'b0;
      hen      <= 1'b0;
      hsync    <= 1'b0;
    end else begin
      hcnt <= nxt;
      if (nxt == LATCH_C) line_len <= CNT_W'(row.length);
      if (row.has_blank) begin
        if (nxt16 == row.blk_clr) hblank <= 1'b0;
        if (nxt16 == row.blk_set) hblank <= 1'b1;
      end
      if (nxt16 == row.en_set) hen <= 1'b1;
      if (nxt16 == row.en_clr) hen <= 1'b0;
      if (nxt == sync_on) begin
        hsync <= 1'b1;
        hen   <= 1'b0;
      end
      if (nxt == sync_off) hsync <= 1'b0;
    end
  end

endmodule

// File: rtl/raster_vtimer.sv
module raster_vtimer
  import raster_pkg::*;
#(
  parameter int       LINE_W = 10,
  parameter vtiming_t V50    = V50_DEF,
  parameter vtiming_t V60    = V60_DEF,
  parameter vtiming_t V72    = V72_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  field_t            field_mode,
  input  logic              decide_s,
  input  logic              wrap_s,
  input  logic              vsync_s,
  output logic [LINE_W-1:0] vcnt,
  output logic              vblank,
  output logic              ven,
  output logic              vsync
);

  localparam int       NMODE = 3;
  localparam vtiming_t VTAB [NMODE] = '{V50, V60, V72};
  localparam logic [2:0] ROW0 = vrow(V50, 16'd0);

  logic [LINE_W-1:0] nl   [NMODE];
  logic [2:0]        nrow [NMODE];
  logic [LINE_W-1:0] sel_line;
  logic [2:0]        sel_row;

  logic [LINE_W-1:0] pend_line;
  logic [2:0]        pend_row;

  for (genvar g = 0; g < NMODE; g++) begin : g_mode
    assign nl[g]   = (16'(vcnt) + 16'd1 >= VTAB[g].total) ? '0 : vcnt + LINE_W'(1);
    assign nrow[g] = vrow(VTAB[g], 16'(nl[g]));
  end

  always_comb begin
    unique case (field_mode)
      FM_60: begin sel_line = nl[1]; sel_row = nrow[1]; end
      FM_72: begin sel_line = nl[2]; sel_row = nrow[2]; end
      default: begin sel_line = nl[0]; sel_row = nrow[0]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt      <= '0;
      vblank    <= ROW0[2];
      ven       <= ROW0[1];
      vsync     <= 1'b0;
      pend_line <= '0;
      pend_row  <= {ROW0[2], ROW0[1], 1'b0};
    end else begin
      if (decide_s) begin
        pend_line <= sel_line;
        pend_row  <= sel_row;
      end
      if (wrap_s) begin
        vcnt   <= pend_line;
        vblank <= pend_row[2];
        ven    <= pend_row[1];
      end
      if (vsync_s) vsync <= pend_row[0];
    end
  end

endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int       DATA_W     = 16,
  parameter int       CNT_W      = 10,
  parameter int       LINE_W     = 10,
  parameter htiming_t H50        = H50_DEF,
  parameter htiming_t H60        = H60_DEF,
  parameter htiming_t H72        = H72_DEF,
  parameter vtiming_t V50        = V50_DEF,
  parameter vtiming_t V60        = V60_DEF,
  parameter vtiming_t V72        = V72_DEF,
  parameter int       SYNC_LEAD  = 48,
  parameter int       SYNC_TRAIL = 8,
  parameter int       LATCH_AT   = 54,
  parameter int       VSYNC_AT   = 54,
  parameter int       DECIDE_AT  = 502
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              disp_en,
  output logic [1:0]        depth,
  output logic [1:0]        field_mode
);

  field_t            mode_w;
  depth_t            depth_w;
  logic [CNT_W-1:0]  hcnt, line_len;
  logic [LINE_W-1:0] vcnt;
  logic              hblank, hen, vblank, ven;
  logic              wrap_s, decide_s, vsync_s;

  raster_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .field_mode(mode_w), .depth(depth_w)
  );

  raster_htimer #(
    .CNT_W(CNT_W), .H50(H50), .H60(H60), .H72(H72),
    .SYNC_LEAD(SYNC_LEAD), .SYNC_TRAIL(SYNC_TRAIL),
    .LATCH_AT(LATCH_AT), .VSYNC_AT(VSYNC_AT), .DECIDE_AT(DECIDE_AT)
  ) htim_i (
    .clk(clk), .rst_n(rst_n), .field_mode(mode_w),
    .hcnt(hcnt), .line_len(line_len), .hblank(hblank), .hen(hen), .hsync(hsync),
    .wrap_s(wrap_s), .decide_s(decide_s), .vsync_s(vsync_s)
  );

  raster_vtimer #(.LINE_W(LINE_W), .V50(V50), .V60(V60), .V72(V72)) vtim_i (
    .clk(clk), .rst_n(rst_n), .field_mode(mode_w),
    .decide_s(decide_s), .wrap_s(wrap_s), .vsync_s(vsync_s),
    .vcnt(vcnt), .vblank(vblank), .ven(ven), .vsync(vsync)
  );

  assign blank      = hblank | vblank;
  assign disp_en    = hen & ven;
  assign depth      = depth_w;
  assign field_mode = mode_w;

endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 10,
  parameter int LINE_W     = 10,
  parameter int SYNC_LEAD  = 48,
  parameter int SYNC_TRAIL = 8,
  parameter int LATCH_AT   = 54,
  parameter int VSYNC_AT   = 54
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              hsync,
  input logic              vsync,
  input logic              disp_en,
  input logic [1:0]        depth,
  input logic [1:0]        field_mode,
  input logic [CNT_W-1:0]  hcnt,
  input logic [CNT_W-1:0]  line_len,
  input logic [LINE_W-1:0] vcnt
);

  localparam int HS_W = SYNC_LEAD - SYNC_TRAIL;

  logic [CNT_W-1:0] hs_run;
  always_ff @(posedge clk) begin
    if (!rst_n)     hs_run <= '0;
    else if (hsync) hs_run <= hs_run + CNT_W'(1);
    else            hs_run <= '0;
  end

  function automatic logic [1:0] dmap(logic [1:0] f);
    return (f == 2'd0) ? 2'd0 : (f == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  assert_rate_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !$past(wr_en && !wr_sel)) |=> $stable(field_mode));

  assert_depth_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (depth == dmap($past(wr_data[9:8]))));

  assert_len_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_len != $past(line_len)) |-> (hcnt == CNT_W'(LATCH_AT)));

  assert_hsync_drops_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> !disp_en);

  assert_hsync_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> (hs_run == CNT_W'(HS_W)));

  assert_line_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != $past(vcnt)) |-> (hcnt == '0));

  assert_vsync_point_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync) || $fell(vsync)) |-> (hcnt == CNT_W'(VSYNC_AT)));

endmodule

bind raster_timer raster_timer_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .LINE_W(LINE_W),
  .SYNC_LEAD(SYNC_LEAD), .SYNC_TRAIL(SYNC_TRAIL),
  .LATCH_AT(LATCH_AT), .VSYNC_AT(VSYNC_AT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .depth(depth),
  .field_mode(field_mode), .hcnt(hcnt), .line_len(line_len), .vcnt(vcnt)
);

// File: tb/raster_timer_tb_top.sv
module raster_timer_tb_top;
  import raster_pkg::*;

  localparam vtiming_t TV50 = '{total: 16'd6, blk_end: 16'd1, en_start: 16'd2, en_end: 16'd4,
                                blk_start: 16'd5, vs_start: 16'd3, vs_end: 16'd4};
  localparam vtiming_t TV60 = '{total: 16'd5, blk_end: 16'd1, en_start: 16'd1, en_end: 16'd3,
                                blk_start: 16'd4, vs_start: 16'd2, vs_end: 16'd3};
  localparam vtiming_t TV72 = '{total: 16'd7, blk_end: 16'd1, en_start: 16'd2, en_end: 16'd5,
                                blk_start: 16'd6, vs_start: 16'd5, vs_end: 16'd6};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic hsync, vsync, blank, disp_en;
  logic [1:0] depth, field_mode;

  int ncyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) ncyc <= rst_n ? ncyc + 1 : 0;

  raster_timer #(.V50(TV50), .V60(TV60), .V72(TV72)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .blank(blank), .disp_en(disp_en),
    .depth(depth), .field_mode(field_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, ncyc, act, expv);
    end
  endtask

  task automatic write_reg(input bit sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(hsync == 1'b0, "R1 hsync", int'(hsync), 0);
    chk(vsync == 1'b0, "R1 vsync", int'(vsync), 0);
    chk(disp_en == 1'b0, "R1 disp_en", int'(disp_en), 0);
    chk(blank == 1'b1, "R1 blank", int'(blank), 1);
    chk(depth == 2'd0, "R1 depth", int'(depth), 0);
    chk(field_mode == 2'd0, "R1 field_mode", int'(field_mode), 0);
    rst_n = 1'b1;
  endtask

  function automatic bit vb(vtiming_t t, int l);
    return (l < int'(t.blk_end)) || (l >= int'(t.blk_start));
  endfunction
  function automatic bit ve(vtiming_t t, int l);
    return (l >= int'(t.en_start)) && (l < int'(t.en_end));
  endfunction
  function automatic bit vs(vtiming_t t, int l);
    return (l >= int'(t.vs_start)) && (l < int'(t.vs_end));
  endfunction

  // Per-cycle sweep over two full frames of one fixed mode
  task automatic run_mode(input int m);
    int len, bc, es, ec, bs;
    bit hasb;
    vtiming_t vt;
    case (m)
      1: begin len = 508; bc = 24; es = 52; ec = 372; bs = 450; hasb = 1; vt = TV60; end
      2: begin len = 224; bc = 0;  es = 4;  ec = 164; bs = 0;   hasb = 0; vt = TV72; end
      default: begin len = 512; bc = 28; es = 56; ec = 376; bs = 450; hasb = 1; vt = TV50; end
    endcase
    do_reset();
    if (m == 1) write_reg(1'b0, 16'h0000);
    if (m == 2) write_reg(1'b1, 16'h0200);
    while (ncyc < 2 * int'(vt.total) * len + 100) begin
      if (ncyc >= 10) begin
        int c, l, lp;
        bit first, ehb, ehe, ehs, evs;
        c = ncyc % len;
        l = (ncyc / len) % int'(vt.total);
        lp = (l + int'(vt.total) - 1) % int'(vt.total);
        first = (ncyc < len);
        ehb = hasb && ((c < bc && !first) || c >= bs);
        ehe = (c >= es) && (c < ec);
        ehs = (c >= len - 48) && (c < len - 8);
        evs = first ? 1'b0 : ((c >= 54) ? vs(vt, l) : vs(vt, lp));
        chk(hsync == ehs, "R6 hsync", int'(hsync), int'(ehs));
        chk(vsync == evs, "R8 vsync", int'(vsync), int'(evs));
        chk(blank == (ehb || vb(vt, l)), "R4/R7 blank", int'(blank), int'(ehb || vb(vt, l)));
        chk(disp_en == (ehe && ve(vt, l)), "R9 disp_en", int'(disp_en), int'(ehe && ve(vt, l)));
      end
      @(negedge clk);
    end
    chk(int'(field_mode) == m, "R3 field_mode", int'(field_mode), m);
    chk(int'(depth) == ((m == 2) ? 2 : 0), "R3 depth", int'(depth), (m == 2) ? 2 : 0);
  endtask

  // Rate write around the latch point; check first two hsync rises
  task automatic latch_case(input int k, input int exp1, input int exp2);
    do_reset();
    while (ncyc != k) @(negedge clk);
    write_reg(1'b0, 16'h0000);
    while (!hsync) @(negedge clk);
    chk(ncyc == exp1, "R5 first hsync rise", ncyc, exp1);
    while (hsync) @(negedge clk);
    while (!hsync) @(negedge clk);
    chk(ncyc == exp2, "R5 second hsync rise", ncyc, exp2);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R2: rate write is delayed one cycle
    write_reg(1'b0, 16'h0000);
    chk(field_mode == 2'd0, "R2 rate not yet applied", int'(field_mode), 0);
    @(negedge clk);
    chk(field_mode == 2'd1, "R2 rate applied", int'(field_mode), 1);
    // R3: depth decode and 72 Hz forcing
    write_reg(1'b1, 16'h0100);
    chk(depth == 2'd1, "R3 depth 2bpp", int'(depth), 1);
    chk(field_mode == 2'd1, "R3 60Hz kept", int'(field_mode), 1);
    write_reg(1'b1, 16'h0200);
    chk(depth == 2'd2, "R3 depth 1bpp", int'(depth), 2);
    chk(field_mode == 2'd2, "R3 forced 72Hz", int'(field_mode), 2);
    write_reg(1'b1, 16'h0300);
    chk(depth == 2'd2, "R3 depth code 3", int'(depth), 2);
    write_reg(1'b0, 16'h0200);
    @(negedge clk);
    chk(field_mode == 2'd2, "R3 rate ignored in 1bpp", int'(field_mode), 2);
    write_reg(1'b1, 16'h0000);
    chk(depth == 2'd0, "R3 depth 4bpp", int'(depth), 0);
    chk(field_mode == 2'd0, "R3 back to 50Hz", int'(field_mode), 0);

    run_mode(0);
    run_mode(1);
    run_mode(2);

    latch_case(38, 460, 968);
    latch_case(98, 464, 972);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule